// File: doc/BRIEF.md
# Event Routing Matrix

This block carries single-cycle event pulses from a bank of peripheral generators to a set of event consumers. It has eight routing channels. Each channel selects one generator line, optionally passes it through a two-flop synchronizer, and runs edge detection on it in one of four modes. A table maps each consumer to one channel or to none. Any number of consumers may listen to the same channel. A control write can also inject an event on a channel, with no generator involved.

Toward each consumer the block uses a valid/ready handshake. `user_evt[u]` is the valid. It rises one clock after the channel event and stays high until the consumer raises `user_ack[u]` (the ready) in a cycle. Each channel reports two status bits: busy, meaning a consumer still holds an event, and ready, meaning consumers are mapped and all of them are idle. Each channel also keeps a sticky detected flag and a sticky overrun flag. An overrun is recorded when a new event reaches a channel while one of its consumers still holds the previous event. The flags have enable set and clear strobes and drive a single interrupt line. A control-register bit resets the whole block synchronously.

Top module: `evr_matrix`

## Requirements
- R1: After reset, `user_evt`, `chan_status`, `int_flags`, `int_en` and `irq` are all zero, and every channel has generator 0, path 0 and edge mode 0.
- R2: A channel write carries the fields in `chan_wdata` as follows.
  - Bits 7:0 hold the channel index. An index of 8 or above makes the whole write, including its software event, have no effect.
  - Bits 23:16 hold the generator. Code 0 selects no generator. Codes 1 to NGEN-1 select `gen_in[code]`. Any higher code acts as no generator.
  - Bits 25:24 hold the path code.
  - Bits 27:26 hold the edge mode.
- R3: The edge mode works on the channel's sampled line. Mode 0 produces no event, 1 fires on a rising edge, 2 on a falling edge and 3 on both edges.
- R4: On path code 0 (synchronous), a `gen_in` change made during a cycle shows on `user_evt` after the next rising clock edge. On path code 1 (resynchronized), it shows two clock edges later. Path codes 2 and 3 behave as code 0.
- R5: Setting bit 8 of a channel write injects exactly one event on the indexed channel. This happens whatever its generator and edge mode are.
- R6: A consumer-map write carries the consumer index in `umux_wdata[7:0]` and the channel number plus one in bits 15:8, where 0 means unmapped.
  - The write is ignored if the consumer index is NUSER or above, or if the field exceeds 8.
  - An unmapped consumer receives no events.
- R7: A channel event sets `user_evt` of every consumer mapped to that channel, and the bit stays high until `user_ack` is seen.
  - If a new event coincides with an acknowledge, `user_evt` stays high.
- R8: In `chan_status`, bits 15:8 are busy per channel: some mapped consumer holds `user_evt` high. Bits 7:0 are ready per channel: at least one consumer is mapped and none is busy.
- R9: Every event on channel c sets `int_flags[8+c]`.
- R10: An event on channel c sets `int_flags[c]` if a consumer mapped to c holds `user_evt` high and is not acknowledging in that cycle.
- R11: Flags are sticky. `flag_clr_wr` clears the flags whose `int_wdata` bits are 1. A flag set in the same cycle stays set.
- R12: `ien_set_wr` sets and `ien_clr_wr` clears the `int_en` bits given in `int_wdata`, and set wins when both strobes arrive together. `irq` is high exactly when some flag is both set and enabled.
- R13: A control write with `ctl_wdata[0]` = 1 returns every channel setting, consumer mapping, held event, flag and enable to its reset value at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control data; bit 0 is the software reset |
| chan_wr | input | 1 | Channel configuration write strobe |
| chan_wdata | input | 32 | Channel index, software event, generator, path, edge mode |
| umux_wr | input | 1 | Consumer-map write strobe |
| umux_wdata | input | 16 | Consumer index and channel-plus-one field |
| ien_set_wr | input | 1 | Interrupt enable set strobe |
| ien_clr_wr | input | 1 | Interrupt enable clear strobe |
| flag_clr_wr | input | 1 | Flag clear (write 1 to clear) strobe |
| int_wdata | input | 16 | Bit mask for the enable and flag strobes |
| gen_in | input | NGEN | Generator event lines; bit 0 is never selected |
| user_ack | input | NUSER | Consumer ready, completes a held event |
| user_evt | output | NUSER | Consumer valid, held until acknowledged |
| chan_status | output | 16 | {busy[7:0], ready[7:0]} |
| int_flags | output | 16 | {detected[7:0], overrun[7:0]} |
| int_en | output | 16 | Interrupt enables, same layout as the flags |
| irq | output | 1 | OR of enabled flags |

## Verification
Two pairs of functions can fall in the same cycle.
- A new channel event can arrive in the very cycle a consumer acknowledges the previous one. The bench forces this with a software event and an acknowledge in one cycle, then judges that `user_evt` stays high and no overrun flag is raised.
- A flag can be set and cleared by a write-1 in the same cycle. The bench pairs a software event with a `flag_clr_wr` on that channel's detected bit and expects the flag to survive.

A long random phase mixes both collisions with generator toggles and reconfiguration, against a behavioural model compared every clock.

// File: rtl/evr_pkg.sv
package evr_pkg;
  typedef enum logic [1:0] {
    PATH_SYNC   = 2'd0,
    PATH_RESYNC = 2'd1,
    PATH_ASYNC  = 2'd2,
    PATH_RSVD   = 2'd3
  } path_e;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_e;

  typedef struct packed {
    logic [7:0] gen;
    path_e      path;
    edge_e      edg;
  } chan_cfg_t;
endpackage

// File: rtl/evr_chan.sv
module evr_chan
  import evr_pkg::*;
#(
  parameter int NGEN   = 60,
  parameter int CH_IDX = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            swrst,
  input  logic            cfg_wr,
  input  logic [7:0]      cfg_idx,
  input  logic            cfg_sw,
  input  logic [7:0]      cfg_gen,
  input  logic [1:0]      cfg_path,
  input  logic [1:0]      cfg_edge,
  input  logic [NGEN-1:0] gen_in,
  output logic            ev
);
  localparam int SELW = 256;

  chan_cfg_t       cfg_q;
  logic [SELW-1:0] gen_ext;
  logic            raw, src, s1_q, s2_q, prev_q, hit, sel_hit;

  assign sel_hit = cfg_wr && (cfg_idx == 8'(CH_IDX));

  always_comb begin
    gen_ext             = '0;
    gen_ext[NGEN-1:0]   = gen_in;
    gen_ext[0]          = 1'b0;   // code 0 means no generator
  end

  assign raw = gen_ext[cfg_q.gen];
  assign src = (cfg_q.path == PATH_RESYNC) ? s2_q : raw;

  always_comb begin
    case (cfg_q.edg)
      EDGE_RISE: hit = src & ~prev_q;
      EDGE_FALL: hit = ~src & prev_q;
      EDGE_BOTH: hit = src ^ prev_q;
      default:   hit = 1'b0;
    endcase
  end

  assign ev = hit | (sel_hit & cfg_sw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '{gen: 8'd0, path: PATH_SYNC, edg: EDGE_OFF};
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else if (swrst) begin
      cfg_q  <= '{gen: 8'd0, path: PATH_SYNC, edg: EDGE_OFF};
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= raw;
      s2_q   <= s1_q;
      prev_q <= src;
      if (sel_hit) begin
        cfg_q.gen  <= cfg_gen;
        cfg_q.path <= path_e'(cfg_path);
        cfg_q.edg  <= edge_e'(cfg_edge);
      end
    end
  end
endmodule

// File: rtl/evr_user_map.sv
module evr_user_map #(
  parameter int NCH   = 8,
  parameter int NUSER = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             swrst,
  input  logic             map_wr,
  input  logic [15:0]      map_wdata,
  input  logic [NCH-1:0]   ev,
  input  logic [NUSER-1:0] user_ack,
  output logic [NUSER-1:0] user_evt,
  output logic [NCH-1:0]   busy_eff,
  output logic [NCH-1:0]   chan_busy,
  output logic [NCH-1:0]   chan_ready
);
  localparam int CW  = $clog2(NCH + 1);
  localparam int EVW = 1 << CW;

  logic [CW-1:0]    map_q [NUSER];
  logic [NUSER-1:0] pend_q;
  logic [EVW-1:0]   ev_sh;
  logic [NCH-1:0]   mapped;
  logic             wr_ok;

  assign wr_ok = map_wr && (map_wdata[7:0] < 8'(NUSER)) && (map_wdata[15:8] <= 8'(NCH));

  always_comb begin
    ev_sh        = '0;
    ev_sh[NCH:1] = ev;   // index 0 = unmapped, never fires
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      for (int u = 0; u < NUSER; u++) map_q[u] <= '0;
    end else if (swrst) begin
      pend_q <= '0;
      for (int u = 0; u < NUSER; u++) map_q[u] <= '0;
    end else begin
      for (int u = 0; u < NUSER; u++) begin
        if (ev_sh[map_q[u]])  pend_q[u] <= 1'b1;
        else if (user_ack[u]) pend_q[u] <= 1'b0;
        if (wr_ok && map_wdata[7:0] == 8'(u)) map_q[u] <= map_wdata[8 +: CW];
      end
    end
  end

  always_comb begin
    mapped    = '0;
    chan_busy = '0;
    busy_eff  = '0;
    for (int u = 0; u < NUSER; u++) begin
      for (int c = 0; c < NCH; c++) begin
        if (map_q[u] == CW'(c + 1)) begin
          mapped[c] = 1'b1;
          if (pend_q[u])                 chan_busy[c] = 1'b1;
          if (pend_q[u] && !user_ack[u]) busy_eff[c]  = 1'b1;
        end
      end
    end
  end

  assign chan_ready = mapped & ~chan_busy;
  assign user_evt   = pend_q;
endmodule

// File: rtl/evr_flags.sv
module evr_flags #(
  parameter int NCH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             swrst,
  input  logic [NCH-1:0]   ev,
  input  logic [NCH-1:0]   busy_eff,
  input  logic             ien_set_wr,
  input  logic             ien_clr_wr,
  input  logic             flag_clr_wr,
  input  logic [2*NCH-1:0] wdata,
  output logic [2*NCH-1:0] flags,
  output logic [2*NCH-1:0] ien,
  output logic             irq
);
  localparam int FW = 2 * NCH;

  logic [FW-1:0] flags_q, ien_q, set_vec, clr_vec;

  assign set_vec = {ev, ev & busy_eff};
  assign clr_vec = flag_clr_wr ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      ien_q   <= '0;
    end else if (swrst) begin
      flags_q <= '0;
      ien_q   <= '0;
    end else begin
      flags_q <= (flags_q & ~clr_vec) | set_vec;
      ien_q   <= ((ien_q & ~(ien_clr_wr ? wdata : '0)) | (ien_set_wr ? wdata : '0));
    end
  end

  assign flags = flags_q;
  assign ien   = ien_q;
  assign irq   = |(flags_q & ien_q);
endmodule

// File: rtl/evr_matrix.sv
module evr_matrix #(
  parameter int NCH   = 8,
  parameter int NUSER = 14,
  parameter int NGEN  = 60
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr,
  input  logic [7:0]         ctl_wdata,
  input  logic               chan_wr,
  input  logic [31:0]        chan_wdata,
  input  logic               umux_wr,
  input  logic [15:0]        umux_wdata,
  input  logic               ien_set_wr,
  input  logic               ien_clr_wr,
  input  logic               flag_clr_wr,
  input  logic [2*NCH-1:0]   int_wdata,
  input  logic [NGEN-1:0]    gen_in,
  input  logic [NUSER-1:0]   user_ack,
  output logic [NUSER-1:0]   user_evt,
  output logic [2*NCH-1:0]   chan_status,
  output logic [2*NCH-1:0]   int_flags,
  output logic [2*NCH-1:0]   int_en,
  output logic               irq
);
  logic           swrst;
  logic [NCH-1:0] ev, busy_eff, chan_busy, chan_ready;
  logic           unused_bits;

  assign swrst       = ctl_wr & ctl_wdata[0];
  assign unused_bits = ^{ctl_wdata[7:1], chan_wdata[15:9], chan_wdata[31:28]};

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    evr_chan #(.NGEN(NGEN), .CH_IDX(c)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .swrst    (swrst),
      .cfg_wr   (chan_wr),
      .cfg_idx  (chan_wdata[7:0]),
      .cfg_sw   (chan_wdata[8]),
      .cfg_gen  (chan_wdata[23:16]),
      .cfg_path (chan_wdata[25:24]),
      .cfg_edge (chan_wdata[27:26]),
      .gen_in   (gen_in),
      .ev       (ev[c])
    );
  end

  evr_user_map #(.NCH(NCH), .NUSER(NUSER)) u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .swrst      (swrst),
    .map_wr     (umux_wr),
    .map_wdata  (umux_wdata),
    .ev         (ev),
    .user_ack   (user_ack),
    .user_evt   (user_evt),
    .busy_eff   (busy_eff),
    .chan_busy  (chan_busy),
    .chan_ready (chan_ready)
  );

  evr_flags #(.NCH(NCH)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .swrst       (swrst),
    .ev          (ev),
    .busy_eff    (busy_eff),
    .ien_set_wr  (ien_set_wr),
    .ien_clr_wr  (ien_clr_wr),
    .flag_clr_wr (flag_clr_wr),
    .wdata       (int_wdata),
    .flags       (int_flags),
    .ien         (int_en),
    .irq         (irq)
  );

  assign chan_status = {chan_busy, chan_ready};
endmodule

// File: rtl/evr_matrix_chk.sv
module evr_matrix_chk #(
  parameter int NCH   = 8,
  parameter int NUSER = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             swrst_req,
  input logic             flag_clr_wr,
  input logic [2*NCH-1:0] int_wdata,
  input logic [NUSER-1:0] user_evt,
  input logic [NUSER-1:0] user_ack,
  input logic [2*NCH-1:0] chan_status,
  input logic [2*NCH-1:0] int_flags,
  input logic [2*NCH-1:0] int_en,
  input logic             irq
);
  localparam int FW = 2 * NCH;

  // R7
  hold_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !swrst_req |=> ((user_evt & $past(user_evt & ~user_ack)) == $past(user_evt & ~user_ack)));

  // R13
  swrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_req |=> (user_evt == '0 && int_flags == '0 && int_en == '0 && !irq));

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !swrst_req |=> ((int_flags & $past(int_flags & ~(flag_clr_wr ? int_wdata : '0)))
                    == $past(int_flags & ~(flag_clr_wr ? int_wdata : '0))));

  // R8
  busy_ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_status[FW-1:NCH] & chan_status[NCH-1:0]) == '0);

  // R10
  ovr_with_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((int_flags[NCH-1:0] & ~$past(int_flags[NCH-1:0])) & ~int_flags[FW-1:NCH]) == '0);

  // R12
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en == '0 || int_flags == '0) |-> !irq);
endmodule

bind evr_matrix evr_matrix_chk #(.NCH(NCH), .NUSER(NUSER)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .swrst_req   (ctl_wr & ctl_wdata[0]),
  .flag_clr_wr (flag_clr_wr),
  .int_wdata   (int_wdata),
  .user_evt    (user_evt),
  .user_ack    (user_ack),
  .chan_status (chan_status),
  .int_flags   (int_flags),
  .int_en      (int_en),
  .irq         (irq)
);

// File: tb/test_evr_matrix.sv
module test_evr_matrix;
  localparam int NCH = 8, NUSER = 14, NGEN = 60, FW = 16;

  logic clk = 0, rst_n = 0;
  logic ctl_wr = 0, chan_wr = 0, umux_wr = 0, ien_set_wr = 0, ien_clr_wr = 0, flag_clr_wr = 0;
  logic [7:0] ctl_wdata = 0;
  logic [31:0] chan_wdata = 0;
  logic [15:0] umux_wdata = 0;
  logic [FW-1:0] int_wdata = 0;
  logic [NGEN-1:0] gen_in = 0;
  logic [NUSER-1:0] user_ack = 0;
  logic [NUSER-1:0] user_evt;
  logic [FW-1:0] chan_status, int_flags, int_en;
  logic irq;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit cmp_on = 0;

  always #10 clk = ~clk;

  evr_matrix #(.NCH(NCH), .NUSER(NUSER), .NGEN(NGEN)) i_evr_matrix (.*);

  // ---------------- behavioural reference model ----------------
  int m_gen [NCH], m_path [NCH], m_edge [NCH], m_map [NUSER];
  logic [NCH-1:0] m_s1, m_s2, m_prev, t_ev, t_busy, t_raw, t_src;
  logic [NUSER-1:0] m_pend;
  logic [FW-1:0] m_flags, m_en;

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin m_gen[c] = 0; m_path[c] = 0; m_edge[c] = 0; end
    for (int u = 0; u < NUSER; u++) m_map[u] = 0;
    m_s1 = 0; m_s2 = 0; m_prev = 0; m_pend = 0; m_flags = 0; m_en = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n || (ctl_wr && ctl_wdata[0])) model_reset();
    else begin
      for (int c = 0; c < NCH; c++) begin
        t_raw[c] = (m_gen[c] > 0 && m_gen[c] < NGEN) ? gen_in[m_gen[c]] : 1'b0;
        t_src[c] = (m_path[c] == 1) ? m_s2[c] : t_raw[c];
        case (m_edge[c])
          1: t_ev[c] = t_src[c] && !m_prev[c];
          2: t_ev[c] = !t_src[c] && m_prev[c];
          3: t_ev[c] = t_src[c] != m_prev[c];
          default: t_ev[c] = 0;
        endcase
        if (chan_wr && chan_wdata[7:0] == c && chan_wdata[8]) t_ev[c] = 1;
        t_busy[c] = 0;
        for (int u = 0; u < NUSER; u++)
          if (m_map[u] == c + 1 && m_pend[u] && !user_ack[u]) t_busy[c] = 1;
      end
      if (flag_clr_wr) m_flags = m_flags & ~int_wdata;
      for (int c = 0; c < NCH; c++)
        if (t_ev[c]) begin m_flags[NCH+c] = 1; if (t_busy[c]) m_flags[c] = 1; end
      if (ien_clr_wr) m_en = m_en & ~int_wdata;
      if (ien_set_wr) m_en = m_en | int_wdata;
      for (int u = 0; u < NUSER; u++)
        if (m_map[u] != 0 && t_ev[m_map[u]-1]) m_pend[u] = 1;
        else if (user_ack[u]) m_pend[u] = 0;
      if (umux_wr && umux_wdata[7:0] < NUSER && umux_wdata[15:8] <= NCH)
        m_map[umux_wdata[7:0]] = umux_wdata[15:8];
      if (chan_wr && chan_wdata[7:0] < NCH) begin
        m_gen[chan_wdata[7:0]]  = chan_wdata[23:16];
        m_path[chan_wdata[7:0]] = chan_wdata[25:24];
        m_edge[chan_wdata[7:0]] = chan_wdata[27:26];
      end
      m_s2 = m_s1; m_s1 = t_raw; m_prev = t_src;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      logic [NCH-1:0] b, mp;
      b = 0; mp = 0;
      for (int u = 0; u < NUSER; u++)
        if (m_map[u] != 0) begin mp[m_map[u]-1] = 1; if (m_pend[u]) b[m_map[u]-1] = 1; end
      chk("R7 user_evt", 32'(user_evt), 32'(m_pend));
      chk("R8 chan_status", 32'(chan_status), 32'({b, mp & ~b}));
      chk("R9 detected flags", 32'(int_flags[FW-1:NCH]), 32'(m_flags[FW-1:NCH]));
      chk("R10 overrun flags", 32'(int_flags[NCH-1:0]), 32'(m_flags[NCH-1:0]));
      chk("R12 int_en", 32'(int_en), 32'(m_en));
      chk("R12 irq", 32'(irq), 32'(|(m_flags & m_en)));
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [31:0] cw(int idx, int gen, int path, int edg, bit sw);
    return {4'd0, 2'(edg), 2'(path), 8'(gen), 7'd0, sw, 8'(idx)};
  endfunction

  task automatic chan_write(logic [31:0] d);
    @(posedge clk); #2; chan_wr = 1; chan_wdata = d;
    @(posedge clk); #2; chan_wr = 0;
  endtask

  task automatic umux_write(int user, int field);
    @(posedge clk); #2; umux_wr = 1; umux_wdata = {8'(field), 8'(user)};
    @(posedge clk); #2; umux_wr = 0;
  endtask

  task automatic ack(logic [NUSER-1:0] m);
    @(posedge clk); #2; user_ack = m;
    @(posedge clk); #2; user_ack = 0;
  endtask

  task automatic set_gen(int i, bit v);
    @(posedge clk); #2; gen_in[i] = v;
  endtask

  task automatic int_write(int kind, logic [FW-1:0] m);
    @(posedge clk); #2; int_wdata = m;
    if (kind == 0) ien_set_wr = 1; else if (kind == 1) ien_clr_wr = 1; else flag_clr_wr = 1;
    @(posedge clk); #2; ien_set_wr = 0; ien_clr_wr = 0; flag_clr_wr = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog (all R) actual=%0d cycles expected=<150000", cyc);
      finish_run();
    end
  end

  // ---------------- directed and random sequence ----------------
  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk("R1 reset user_evt", 32'(user_evt), 0);
    chk("R1 reset status", 32'(chan_status), 0);
    chk("R1 reset flags/en/irq", {int_flags, int_en} | 32'(irq), 0);
    cmp_on = 1;

    umux_write(0, 1); umux_write(1, 1); umux_write(2, 4); umux_write(3, 2);
    chan_write(cw(0, 5, 0, 1, 0));
    chan_write(cw(1, 6, 1, 1, 0));
    int_write(0, 16'hFFFF);

    // R4 synchronous path: visible after one edge
    set_gen(5, 1);
    @(negedge clk); chk("R4 sync before edge", 32'(user_evt[1:0]), 0);
    @(negedge clk); chk("R4 sync after edge", 32'(user_evt[1:0]), 3);
    ack(14'h3);
    // R4 resynchronized path: two more edges
    set_gen(6, 1);
    repeat (3) @(negedge clk);
    chk("R4 resync early", 32'(user_evt[3]), 0);
    @(negedge clk); chk("R4 resync arrival", 32'(user_evt[3]), 1);
    ack(14'h8);

    // R3 falling edge only
    chan_write(cw(3, 7, 0, 2, 0));
    set_gen(7, 1);
    repeat (2) @(negedge clk); chk("R3 falling ignores rise", 32'(user_evt[2]), 0);
    set_gen(7, 0);
    repeat (2) @(negedge clk); chk("R3 falling fires", 32'(user_evt[2]), 1);
    // R10 both edges while consumer 2 still holds: overrun
    chan_write(cw(3, 7, 0, 3, 0));
    set_gen(7, 1);
    repeat (2) @(negedge clk); chk("R10 overrun set", 32'(int_flags[3]), 1);
    ack(14'h4);

    // R5 software event with edge mode off
    umux_write(4, 3);
    chan_write(cw(2, 0, 0, 0, 1));
    @(negedge clk); chk("R5 software event", 32'(user_evt[4]), 1);

    // R7 new event coinciding with acknowledge
    @(posedge clk); #2; chan_wr = 1; chan_wdata = cw(2, 0, 0, 0, 1); user_ack = 14'h10;
    @(posedge clk); #2; chan_wr = 0; user_ack = 0;
    @(negedge clk);
    chk("R7 event with ack stays high", 32'(user_evt[4]), 1);
    chk("R10 no overrun on ack cycle", 32'(int_flags[2]), 0);

    // R11 set wins over write-1 clear
    @(posedge clk); #2; chan_wr = 1; chan_wdata = cw(2, 0, 0, 0, 1);
    flag_clr_wr = 1; int_wdata = 16'h0400;
    @(posedge clk); #2; chan_wr = 0; flag_clr_wr = 0;
    @(negedge clk); chk("R11 set beats clear", 32'(int_flags[10]), 1);
    int_write(2, 16'h0400);
    @(negedge clk); chk("R11 write-1 clears", 32'(int_flags[10]), 0);

    // R12 enable set/clear and irq
    int_write(1, 16'hFFFF);
    @(negedge clk); chk("R12 irq masked", 32'(irq), 0);
    int_write(0, 16'h0004);
    @(negedge clk); chk("R12 enable set", 32'(int_en), 32'h0004);
    chk("R12 irq from overrun ch2", 32'(irq), 1);

    // R2 out-of-range channel index ignored
    ack('1);
    int_write(2, 16'hFFFF);
    chan_write(cw(9, 0, 0, 0, 1));
    @(negedge clk); chk("R2 bad index no event", {16'(user_evt), int_flags}, 0);

    // R6 invalid map writes ignored, unmapped consumer silent
    umux_write(20, 1);
    umux_write(4, 9);
    chan_write(cw(2, 0, 0, 0, 1));
    @(negedge clk); chk("R6 bad map write ignored", 32'(user_evt[4]), 1);
    ack(14'h10);
    umux_write(4, 0);
    chan_write(cw(2, 0, 0, 0, 1));
    @(negedge clk);
    chk("R6 unmapped consumer idle", 32'(user_evt[4]), 0);
    chk("R9 detected without consumers", 32'(int_flags[10]), 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #2;
      if ($urandom % 3 == 0) gen_in[$urandom % NGEN] ^= 1'b1;
      user_ack    = ($urandom % 2) ? 14'($urandom) : '0;
      chan_wr     = ($urandom % 6 == 0);
      chan_wdata  = cw($urandom % 10, $urandom % 64, $urandom % 4, $urandom % 4, $urandom % 4 == 0);
      umux_wr     = ($urandom % 8 == 0);
      umux_wdata  = {8'($urandom % 10), 8'($urandom % 16)};
      flag_clr_wr = ($urandom % 10 == 0);
      ien_set_wr  = ($urandom % 12 == 0);
      ien_clr_wr  = ($urandom % 12 == 0);
      int_wdata   = 16'($urandom);
      ctl_wr      = ($urandom % 700 == 0);
      ctl_wdata   = 8'($urandom);
    end
    @(posedge clk); #2;
    chan_wr = 0; umux_wr = 0; flag_clr_wr = 0; ien_set_wr = 0; ien_clr_wr = 0; ctl_wr = 0; user_ack = 0;

    // R13 software reset
    umux_write(0, 1);
    chan_write(cw(0, 0, 0, 0, 1));
    int_write(0, 16'hFFFF);
    @(posedge clk); #2; ctl_wr = 1; ctl_wdata = 8'h01;
    @(posedge clk); #2; ctl_wr = 0;
    @(negedge clk);
    chk("R13 reset clears outputs", {16'(user_evt), int_flags}, 0);
    chk("R13 reset clears enables", {int_en, chan_status}, 0);
    chan_write(cw(0, 0, 0, 0, 1));
    @(negedge clk); chk("R13 mapping cleared", 32'(user_evt), 0);

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule